// File: doc/BRIEF.md
# Half-Ratio Memory Clock Divider

This block derives a memory clock from the core clock with a divide ratio chosen by a 3-bit code: whole ratios 2, 3, 4 and 5 and half ratios 2.5, 3.5 and 4.5. All logic runs on the rising edge of the core clock. The divider works in half-cycle slots of the core clock, so each core cycle it emits a pair of levels, `mclk_ph[0]` for the first half and `mclk_ph[1]` for the second. A double-data-rate output cell at the pad serializes this pair into the memory clock. `mclk_rise` marks every core cycle in which a memory clock period begins. It can serve as a clock-enable for logic that stays in the core clock domain.

The ratio code is only sampled when the `start` input rises from 0 to 1. Software writes `start` low and then high to begin clocking or to change the ratio. The code is ignored at all other times. Once the divider is running, a newly captured ratio waits as a pending value and takes over at the next boundary between memory clock periods. That boundary may fall in the middle of a core cycle. This gives a glitch-free handover. The divider leaves reset stopped. It starts on the first start edge that carries a valid code and then runs until the next reset.

The controller has three named states. STOPPED is the reset state and outputs no clock. STEADY runs at the current ratio. HANDOVER runs at the current ratio while a pending ratio waits for the period boundary. The transitions are:
- *launch*: STOPPED to STEADY, on a start edge with a nonzero code.
- *request*: STEADY to HANDOVER, on a start edge with a nonzero code.
- *retarget*: HANDOVER to HANDOVER, on another such edge. It replaces the pending ratio.
- *adopt*: HANDOVER to STEADY, when the pending ratio is applied at a boundary and no new edge arrives in the same cycle.

Top module: `hr_mem_clk_div`

## Requirements
- R1: While reset is high and in the first cycle after it, `running` is 0, `mclk_ph` is 2'b00 and `mclk_rise` is 0.
- R2: With ratio code c (1 to 7), one memory clock period lasts c+3 half core cycles. The period opens with a high phase of ceil((c+3)/2) half cycles, and the low phase fills the rest. In the slot pair, `mclk_ph[0]` is the level in the first half of the core cycle and `mclk_ph[1]` the level in the second half.
- R3: A start edge (start 1 at a rising clock edge where it was 0 at the previous one) with a nonzero code, taken while stopped, produces in the next cycle `running`=1, `mclk_rise`=1 and `mclk_ph`=2'b11.
- R4: The recorded previous value of `start` resets to 1. So holding `start` at 1 through and after reset starts nothing, and keeping it at 1 never re-captures a code.
- R5: Code 3'b000 is reserved. A start edge carrying it leaves a stopped divider stopped and leaves a running divider at its present ratio.
- R6: A change to the ratio code without a start edge has no effect on the outputs.
- R7: A ratio captured while running takes effect at the first boundary between memory clock periods, including a boundary that falls between the two half slots of a core cycle. If a further edge arrives before that boundary, only the latest captured ratio is applied.
- R8: `mclk_rise` is 1 exactly in the core cycles in which either half slot is the first slot of a memory clock period.
- R9: Once `running` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_code | input | CODE_W (3) | Divide ratio code, sampled on a start edge |
| start | input | 1 | Start or ratio-change control, acts on a 0-to-1 rise |
| mclk_ph | output | 2 | Memory clock level for the first half [0] and the second half [1] of the core cycle |
| mclk_rise | output | 1 | High in core cycles where a memory clock period begins |
| running | output | 1 | High once the divider has started |

## Verification
A half-slot reference model runs beside the design and predicts every output pair. It is driven through a sweep of all seven codes, with start edges placed at varying offsets within the memory clock period. Each ratio therefore hands over to the next from both even and odd slot positions, which separates a handover at a whole-cycle boundary from one in the middle of a cycle. A start held high out of reset, and code changes without an edge, separate an edge-triggered capture from a level-triggered one. Reserved-code edges while stopped and while running, and two edges in quick succession before a boundary, show whether the design applies the latest valid request and drops the reserved one.

// File: rtl/hrdiv_pkg.sv
package hrdiv_pkg;
    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_STEADY   = 2'd1,
        ST_HANDOVER = 2'd2
    } hr_state_e;
endpackage

// File: rtl/hr_cmd_capture.sv
// Detects a 0-to-1 rise of start and qualifies it with a nonzero ratio code.
module hr_cmd_capture #(
    parameter int CODE_W = 3,
    parameter int BIAS   = 3,
    parameter int PW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              cmd_ok,
    output logic [PW-1:0]     cmd_period
);
    logic start_q;

    // Previous start resets to 1: a level held through reset is not an edge (R4).
    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b1;
        else     start_q <= start;
    end

    // Reserved code zero is never accepted (R5).
    assign cmd_ok     = start && !start_q && (ratio_code != '0);
    assign cmd_period = PW'(ratio_code) + PW'(BIAS);
endmodule

// File: rtl/hr_slot_engine.sv
// Computes the two half-slot levels of one core cycle and the position
// after it, switching to a pending period at the first period boundary.
module hr_slot_engine #(
    parameter int PW = 4
) (
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] cur_p,
    input  logic          pend_vld,
    input  logic [PW-1:0] pend_p,
    output logic [1:0]    lvl,
    output logic          rise,
    output logic [PW-1:0] nxt_pos,
    output logic [PW-1:0] nxt_p,
    output logic          pend_used
);
    function automatic logic [PW-1:0] high_len(input logic [PW-1:0] p);
        logic [PW:0] t;
        t = {1'b0, p} + 1'b1;
        return t[PW:1];
    endfunction

    logic          wrap0, wrap1;
    logic [PW-1:0] pos1, p1;

    always_comb begin
        wrap0 = (pos == cur_p - 1'b1);
        if (wrap0) begin
            pos1 = '0;
            p1   = pend_vld ? pend_p : cur_p;
        end else begin
            pos1 = pos + 1'b1;
            p1   = cur_p;
        end
        wrap1 = (pos1 == p1 - 1'b1);

        lvl[0] = (pos  < high_len(cur_p));
        lvl[1] = (pos1 < high_len(p1));
        rise   = (pos == '0) || (pos1 == '0);

        if (wrap1) begin
            nxt_pos   = '0;
            nxt_p     = (pend_vld && !wrap0) ? pend_p : p1;
            pend_used = pend_vld;
        end else begin
            nxt_pos   = pos1 + 1'b1;
            nxt_p     = p1;
            pend_used = pend_vld && wrap0;
        end
    end
endmodule

// File: rtl/hr_mem_clk_div.sv
module hr_mem_clk_div #(
    parameter int CODE_W   = 3,
    parameter int BIAS     = 3,
    parameter int DEF_CODE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              start,
    output logic [1:0]        mclk_ph,
    output logic              mclk_rise,
    output logic              running
);
    import hrdiv_pkg::*;

    localparam int PMAX = (1 << CODE_W) - 1 + BIAS;
    localparam int PW   = $clog2(PMAX + 1);

    hr_state_e     state, state_nx;
    logic [PW-1:0] pos, pos_nx, cur_p, cur_nx, pend_p, pend_nx;

    logic          cmd_ok;
    logic [PW-1:0] cmd_period;
    logic [1:0]    eng_lvl;
    logic          eng_rise, eng_used;
    logic [PW-1:0] eng_pos, eng_p;

    hr_cmd_capture #(.CODE_W(CODE_W), .BIAS(BIAS), .PW(PW)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ratio_code (ratio_code),
        .cmd_ok     (cmd_ok),
        .cmd_period (cmd_period)
    );

    hr_slot_engine #(.PW(PW)) u_eng (
        .pos       (pos),
        .cur_p     (cur_p),
        .pend_vld  (state == ST_HANDOVER),
        .pend_p    (pend_p),
        .lvl       (eng_lvl),
        .rise      (eng_rise),
        .nxt_pos   (eng_pos),
        .nxt_p     (eng_p),
        .pend_used (eng_used)
    );

    // State register with its datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_STOPPED;
            pos    <= '0;
            cur_p  <= PW'(DEF_CODE + BIAS);
            pend_p <= PW'(DEF_CODE + BIAS);
        end else begin
            state  <= state_nx;
            pos    <= pos_nx;
            cur_p  <= cur_nx;
            pend_p <= pend_nx;
        end
    end

    // Transitions: launch, request, retarget, adopt
    always_comb begin
        state_nx = state;
        pos_nx   = pos;
        cur_nx   = cur_p;
        pend_nx  = pend_p;
        unique case (state)
            ST_STOPPED: begin
                if (cmd_ok) begin
                    state_nx = ST_STEADY;
                    pos_nx   = '0;
                    cur_nx   = cmd_period;
                end
            end
            ST_STEADY: begin
                pos_nx = eng_pos;
                cur_nx = eng_p;
                if (cmd_ok) begin
                    state_nx = ST_HANDOVER;
                    pend_nx  = cmd_period;
                end
            end
            ST_HANDOVER: begin
                pos_nx = eng_pos;
                cur_nx = eng_p;
                if (cmd_ok)        pend_nx  = cmd_period;
                else if (eng_used) state_nx = ST_STEADY;
            end
            default: state_nx = ST_STOPPED;
        endcase
    end

    // Outputs
    always_comb begin
        running   = (state != ST_STOPPED);
        mclk_ph   = running ? eng_lvl : 2'b00;
        mclk_rise = running && eng_rise;
    end
endmodule

// File: rtl/hr_mem_clk_div_chk.sv
module hr_mem_clk_div_chk #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CODE_W-1:0] ratio_code,
    input logic [1:0]        mclk_ph,
    input logic              mclk_rise,
    input logic              running
);
    logic start_prev;
    always_ff @(posedge clk) begin
        if (rst) start_prev <= 1'b1;
        else     start_prev <= start;
    end

    logic st_edge;
    assign st_edge = start && !start_prev;

    a_r1_stopped_silent: assert property (@(posedge clk) disable iff (rst)
        !running |-> (mclk_ph == 2'b00 && !mclk_rise));

    a_r3_launch_high: assert property (@(posedge clk) disable iff (rst)
        (st_edge && ratio_code != '0 && !running) |=> (running && mclk_rise && mclk_ph == 2'b11));

    a_r5_reserved_no_launch: assert property (@(posedge clk) disable iff (rst)
        (st_edge && ratio_code == '0 && !running) |=> !running);

    a_r4_no_edge_no_launch: assert property (@(posedge clk) disable iff (rst)
        (!running && !st_edge) |=> !running);

    a_r9_running_sticky: assert property (@(posedge clk) disable iff (rst)
        running |=> running);

    a_r8_rise_in_high: assert property (@(posedge clk) disable iff (rst)
        mclk_rise |-> (mclk_ph != 2'b00));
endmodule

bind hr_mem_clk_div hr_mem_clk_div_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ratio_code (ratio_code),
    .mclk_ph    (mclk_ph),
    .mclk_rise  (mclk_rise),
    .running    (running)
);

// File: tb/tb_hr_mem_clk_div.sv
module tb_hr_mem_clk_div;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ratio_code = 3'd3;
    logic       start = 1'b1;
    logic [1:0] mclk_ph;
    logic       mclk_rise, running;

    int n_checks = 0;
    int n_fails  = 0;
    string cur_req = "R1";
    logic [3:0] exp_q[$];

    always #4 clk = ~clk;

    hr_mem_clk_div dut (
        .clk(clk), .rst(rst), .ratio_code(ratio_code), .start(start),
        .mclk_ph(mclk_ph), .mclk_rise(mclk_rise), .running(running)
    );

    task automatic check(input logic ok, input string req, input logic [3:0] act, input logic [3:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual {run,rise,ph}=%b expected %b at %0t", req, act, expv, $time);
        end
    endtask

    // Reference model at half-slot granularity; pushes expected items.
    int m_run, m_prev, m_P, m_pend, m_idx;
    always @(posedge clk) begin
        logic [1:0] lv;
        logic       rs;
        if (rst) begin
            m_run = 0; m_prev = 1; m_P = 6; m_pend = 0; m_idx = 0;
        end else begin
            if (start && m_prev == 0 && ratio_code != 3'd0) begin
                if (m_run == 0) begin m_run = 1; m_P = ratio_code + 3; m_idx = 0; end
                else m_pend = ratio_code + 3;
            end
            m_prev = start;
            lv = 2'b00; rs = 1'b0;
            if (m_run != 0) begin
                for (int s = 0; s < 2; s++) begin
                    lv[s] = (m_idx < (m_P + 1) / 2);
                    if (m_idx == 0) rs = 1'b1;
                    m_idx++;
                    if (m_idx == m_P) begin
                        m_idx = 0;
                        if (m_pend != 0) begin m_P = m_pend; m_pend = 0; end
                    end
                end
            end
            exp_q.push_back({(m_run != 0), rs, lv});
        end
    end

    // Monitor: pops and compares away from the active edge.
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            logic [3:0] e, a;
            e = exp_q.pop_front();
            a = {running, mclk_rise, mclk_ph};
            check(a == e, cur_req, a, e);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk); #1;
    endtask

    task automatic expect_stopped(input string req);
        check(!running && mclk_ph == 2'b00 && !mclk_rise, req,
              {running, mclk_rise, mclk_ph}, 4'b0000);
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        cyc(4);
        expect_stopped("R1");
        rst = 1'b0;
        @(negedge clk); #1;
        expect_stopped("R1");
        cur_req = "R4";                        // start held high out of reset
        cyc(5);
        expect_stopped("R4");
        start = 1'b0; cyc(2);
        cur_req = "R5"; ratio_code = 3'd0; start = 1'b1; cyc(3);
        expect_stopped("R5");
        start = 1'b0; cyc(1);
        cur_req = "R6"; ratio_code = 3'd5; cyc(3);  // code change, no edge
        expect_stopped("R6");
        cur_req = "R3"; start = 1'b1;
        @(posedge clk); @(negedge clk); #1;
        check(running && mclk_rise && mclk_ph == 2'b11, "R3",
              {running, mclk_rise, mclk_ph}, 4'b1111);
        cur_req = "R2"; cyc(24);
        cur_req = "R6"; ratio_code = 3'd7; cyc(20);
        cur_req = "R7"; start = 1'b0; cyc(1); start = 1'b1; cyc(30);
        for (int c = 1; c < 8; c++) begin
            cur_req = "R7";
            start = 1'b0; cyc(1 + c % 3);
            ratio_code = 3'(c); start = 1'b1; cyc(3 * c + 7);
        end
        for (int c = 7; c > 0; c -= 2) begin
            cur_req = "R2";
            start = 1'b0; cyc(2);
            ratio_code = 3'(c); start = 1'b1; cyc(25);
        end
        cur_req = "R5"; start = 1'b0; ratio_code = 3'd0; cyc(1); start = 1'b1; cyc(20);
        check(running, "R9", {running, mclk_rise, mclk_ph}, {1'b1, mclk_rise, mclk_ph});
        cur_req = "R7"; start = 1'b0; ratio_code = 3'd2; cyc(1); start = 1'b1; cyc(1);
        start = 1'b0; ratio_code = 3'd6; cyc(1); start = 1'b1; cyc(30);
        cur_req = "R4"; ratio_code = 3'd1; cyc(20);   // held high, new code ignored
        cur_req = "R8"; start = 1'b0; ratio_code = 3'd4; cyc(1); start = 1'b1; cyc(30);
        rst = 1'b1; cyc(2);
        expect_stopped("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule